// File: doc/BRIEF.md
# Six-Channel Gate Enable and Drain-Sample Timing

This block drives the logic level of six gate outputs and decides when each channel's drain comparator result may be trusted. A gate is on only while the power-on reset is released, the reset pin is high, the enable pin is low, no short is latched for that channel, and the channel is requested on. A request comes from the parallel input bit or from the serial-register gate bit.

Each channel owns a blanking counter and a filter counter. A change in the requested state starts the blanking counter. The on-going or off-going blanking length comes from a per-channel two-bit selection. A rising edge on the drain comparator starts the filter counter, and this can happen while blanking is running. The channel emits a one-cycle sample strobe once both counters are idle again. When the block becomes active, every channel restarts its blanking. This happens after power-on, when the reset pin rises with enable low, and when enable falls with the reset pin high. While the block is disabled, all counters stay cleared and no strobe is issued.

Top module: `gate_blank_ctrl`

## Requirements
- R1: `gate[i]` is high exactly when `por_n`=1, `rst_pin`=1, `en_n`=0, `short_lat[i]`=0 and (`par_in[i]` or `spi_gate[i]`) is 1. It follows its inputs combinationally.
- R2: While `por_n`=0, every `gate` bit and every `sample` bit is 0.
- R3: A 0-to-1 change of the request (`par_in[i]|spi_gate[i]`) while active loads the on-blanking length BLK_BASE<<s. Here s is `blank_sel_on[2i+1:2i]`. With BLK_BASE=4, `sample[i]` is first seen high after the (4<<s)+1-th rising edge, counting the edge that captures the change.
- R4: A 1-to-0 change of the request loads the off-blanking length BLK_BASE<<s. Here s is `blank_sel_off[2i+1:2i]`. The strobe has the same timing as in R3.
- R5: Each blanking or filter expiry yields a strobe exactly one cycle wide on that channel only.
- R6: In a stable state, a 0-to-1 edge of `drn_cmp[i]` starts a FILT_CYC-cycle filter. With FILT_CYC=6, the strobe follows 7 edges after the change. A level held high does not restart the filter.
- R7: A filter started during blanking postpones the strobe until the filter ends, and only one strobe is issued.
- R8: A change of the blanking selection while blanking runs does not alter the running interval. The new value is used at the next start.
- R9: When the block becomes active, all channels restart blanking with the length for their current request state. The block becomes active after `por_n` release, on `rst_pin` rising while `en_n`=0, and on `en_n` falling while `rst_pin`=1.
- R10: While `en_n`=1 or `rst_pin`=0, all gates are low and no strobe is issued. Running intervals are discarded, and drain edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Reset pin, high to run |
| en_n | input | 1 | Enable pin, low to enable |
| par_in | input | NCH | Parallel gate requests |
| spi_gate | input | NCH | Register gate requests |
| short_lat | input | NCH | Latched short per channel |
| drn_cmp | input | NCH | Drain comparator fault-threshold result |
| blank_sel_on | input | NCH*SW | On-blanking selection, SW bits per channel |
| blank_sel_off | input | NCH*SW | Off-blanking selection, SW bits per channel |
| gate | output | NCH | Gate levels |
| sample | output | NCH | One-cycle drain-sample strobes |

## Verification
A blanking interval and a filter interval can both be running on one channel. The end of one can then coincide with the other still counting. The bench provokes this by raising the drain comparator two cycles into a four-cycle on-blanking. It judges the result by requiring a single strobe at the filter's end, not the blanking's. A second overlap puts a selection change in the middle of a running interval, and the bench expects the old length. A third disables the block in the middle of blanking, and the bench expects no strobe.

// File: rtl/gate_blank_ctrl.sv
module gate_blank_ctrl #(
  parameter int NCH      = 6,
  parameter int SW       = 2,
  parameter int BLK_BASE = 4,
  parameter int FILT_CYC = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin,
  input  logic              en_n,
  input  logic [NCH-1:0]    par_in,
  input  logic [NCH-1:0]    spi_gate,
  input  logic [NCH-1:0]    short_lat,
  input  logic [NCH-1:0]    drn_cmp,
  input  logic [NCH*SW-1:0] blank_sel_on,
  input  logic [NCH*SW-1:0] blank_sel_off,
  output logic [NCH-1:0]    gate,
  output logic [NCH-1:0]    sample
);
  localparam int BMAX = BLK_BASE << ((1 << SW) - 1);
  localparam int TMAX = (BMAX > FILT_CYC) ? BMAX : FILT_CYC;
  localparam int CW   = $clog2(TMAX + 1);

  logic           act, act_q, restart;
  logic [NCH-1:0] cmd, cmd_q, drn_q, fire;

  assign act     = rst_pin & ~en_n;
  assign restart = act & ~act_q;
  assign cmd     = par_in | spi_gate;
  assign gate    = {NCH{por_n & act}} & ~short_lat & cmd;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      act_q  <= 1'b0;
      cmd_q  <= '0;
      drn_q  <= '0;
      sample <= '0;
    end else begin
      act_q  <= act;
      cmd_q  <= cmd;
      drn_q  <= drn_cmp;
      sample <= fire;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SW-1:0] s_on, s_off;
    logic [CW-1:0] len, blk_q, blk_d, flt_q, flt_d;
    logic          st_b, st_f, busy;

    assign s_on  = blank_sel_on[i*SW +: SW];
    assign s_off = blank_sel_off[i*SW +: SW];
    assign len   = cmd[i] ? (CW'(BLK_BASE) << s_on) : (CW'(BLK_BASE) << s_off);
    assign st_b  = act & (restart | (cmd[i] ^ cmd_q[i]));
    assign st_f  = act & ~restart & drn_cmp[i] & ~drn_q[i] & (flt_q == '0);
    assign busy  = (blk_q != '0) | (flt_q != '0);

    always_comb begin
      if (!act)               blk_d = '0;
      else if (st_b)          blk_d = len;
      else if (blk_q != '0)   blk_d = blk_q - CW'(1);
      else                    blk_d = '0;
      if (!act)               flt_d = '0;
      else if (st_f)          flt_d = CW'(FILT_CYC);
      else if (flt_q != '0)   flt_d = flt_q - CW'(1);
      else                    flt_d = '0;
    end

    assign fire[i] = act & busy & (blk_d == '0) & (flt_d == '0);

    always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
        blk_q <= '0;
        flt_q <= '0;
      end else begin
        blk_q <= blk_d;
        flt_q <= flt_d;
      end
  end
endmodule

// File: rtl/gate_blank_ctrl_chk.sv
module gate_blank_ctrl_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           por_n,
  input logic           rst_pin,
  input logic           en_n,
  input logic [NCH-1:0] par_in,
  input logic [NCH-1:0] spi_gate,
  input logic [NCH-1:0] short_lat,
  input logic [NCH-1:0] gate,
  input logic [NCH-1:0] sample
);
  always_comb
    if (!por_n) a_por_quiet_r2: assert (gate == '0);

  p_gate_needs_req_r1: assert property (@(posedge clk) disable iff (!por_n)
    (gate & ~(par_in | spi_gate)) == '0);

  p_gate_short_r1: assert property (@(posedge clk) disable iff (!por_n)
    (gate & short_lat) == '0);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!por_n)
    (sample != '0) |=> ((sample & $past(sample)) == '0));

  p_no_strobe_disabled_r10: assert property (@(posedge clk) disable iff (!por_n)
    ($past(en_n) || !$past(rst_pin)) |-> (sample == '0));

  p_enable_restart_r9: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(en_n) && rst_pin) |=> (sample == '0));

  p_reset_restart_r9: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_pin) && !en_n) |=> (sample == '0));
endmodule

bind gate_blank_ctrl gate_blank_ctrl_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/gate_blank_ctrl_test.sv
`timescale 1ns/1ps
module gate_blank_ctrl_test;
  localparam int NCH = 6;
  localparam int SW  = 2;

  logic clk = 1'b0;
  logic por_n, rst_pin, en_n;
  logic [NCH-1:0] par_in, spi_gate, short_lat, drn_cmp, gate, sample;
  logic [NCH*SW-1:0] sel_on, sel_off;

  int total = 0, bad = 0;
  int first [NCH];
  int hits  [NCH];

  always #5 clk = ~clk;

  gate_blank_ctrl uut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .en_n(en_n),
    .par_in(par_in), .spi_gate(spi_gate), .short_lat(short_lat),
    .drn_cmp(drn_cmp), .blank_sel_on(sel_on), .blank_sel_off(sel_off),
    .gate(gate), .sample(sample));

  // {ch[2:0], dir, src(1=spi), sel[1:0], expected first strobe edge[7:0]}
  localparam logic [14:0] VEC [8] = '{
    {3'd0, 1'b1, 1'b0, 2'd0, 8'd5},
    {3'd0, 1'b0, 1'b0, 2'd1, 8'd9},
    {3'd2, 1'b1, 1'b1, 2'd3, 8'd33},
    {3'd2, 1'b0, 1'b0, 2'd2, 8'd17},
    {3'd5, 1'b1, 1'b0, 2'd1, 8'd9},
    {3'd5, 1'b0, 1'b0, 2'd3, 8'd33},
    {3'd3, 1'b1, 1'b1, 2'd2, 8'd17},
    {3'd3, 1'b0, 1'b0, 2'd0, 8'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_watch(input int limit, input int inj_at, input int kind, input logic [NCH-1:0] mask);
    for (int c = 0; c < NCH; c++) begin first[c] = 0; hits[c] = 0; end
    for (int n = 1; n <= limit; n++) begin
      @(posedge clk); @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if (sample[c]) begin hits[c]++; if (first[c] == 0) first[c] = n; end
      if (n == inj_at) begin
        case (kind)
          1: drn_cmp = drn_cmp | mask;
          2: en_n = 1'b1;
          3: sel_on = '0;
          default: ;
        endcase
      end
    end
  endtask

  function automatic int blank_exp(input int c);
    logic [SW-1:0] s;
    s = (par_in[c] | spi_gate[c]) ? sel_on[c*SW +: SW] : sel_off[c*SW +: SW];
    return (4 << s) + 1;
  endfunction

  task automatic check_restart(input string req);
    run_watch(40, 0, 0, '0);
    for (int c = 0; c < NCH; c++) begin
      chk(first[c] == blank_exp(c), req, first[c], blank_exp(c));
      chk(hits[c] == 1, "R5", hits[c], 1);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 0; rst_pin = 1; en_n = 0;
    par_in = '0; spi_gate = '0; short_lat = '0; drn_cmp = '0;
    sel_on = '0; sel_off = '0;
    idle(3);
    par_in = '1;
    #1;
    chk(gate == '0, "R2", gate, 0);
    chk(sample == '0, "R2", sample, 0);
    idle(2);
    chk(sample == '0, "R2", sample, 0);
    por_n = 1;
    #1;
    chk(gate == 6'h3F, "R1", gate, 6'h3F);
    check_restart("R9");

    short_lat = 6'h05; #1;
    chk(gate == 6'h3A, "R1", gate, 6'h3A);
    short_lat = '0; par_in = '0; spi_gate = 6'h12; #1;
    chk(gate == 6'h12, "R1", gate, 6'h12);
    rst_pin = 0; #1;
    chk(gate == '0, "R1", gate, 0);
    rst_pin = 1; #1;
    chk(gate == 6'h12, "R1", gate, 6'h12);
    spi_gate = '0;
    idle(45);

    for (int v = 0; v < 8; v++) begin
      automatic int ch  = int'(VEC[v][14:12]);
      automatic bit dir = VEC[v][11];
      automatic bit src = VEC[v][10];
      automatic int e   = int'(VEC[v][7:0]);
      if (dir) sel_on[ch*SW +: SW] = VEC[v][9:8];
      else     sel_off[ch*SW +: SW] = VEC[v][9:8];
      if (dir && src) spi_gate[ch] = 1'b1;
      else if (dir)   par_in[ch] = 1'b1;
      else begin par_in[ch] = 1'b0; spi_gate[ch] = 1'b0; end
      run_watch(40, 0, 0, '0);
      chk(first[ch] == e, dir ? "R3" : "R4", first[ch], e);
      chk(hits[ch] == 1, "R5", hits[ch], 1);
      for (int c = 0; c < NCH; c++)
        if (c != ch) chk(hits[c] == 0, "R5 other channel", hits[c], 0);
    end

    drn_cmp[1] = 1'b1;
    run_watch(20, 0, 0, '0);
    chk(first[1] == 7, "R6", first[1], 7);
    chk(hits[1] == 1, "R6 held level", hits[1], 1);
    drn_cmp = '0;
    idle(2);

    sel_on[1*SW +: SW] = 2'd0;
    par_in[1] = 1'b1;
    run_watch(20, 2, 1, 6'h02);
    chk(first[1] == 9, "R7", first[1], 9);
    chk(hits[1] == 1, "R7 single strobe", hits[1], 1);
    drn_cmp = '0;
    idle(2);

    sel_on[4*SW +: SW] = 2'd2;
    sel_off[4*SW +: SW] = 2'd0;
    par_in[4] = 1'b1;
    run_watch(30, 3, 3, '0);
    chk(first[4] == 17, "R8 running", first[4], 17);
    par_in[4] = 1'b0;
    idle(20);
    par_in[4] = 1'b1;
    run_watch(20, 0, 0, '0);
    chk(first[4] == 5, "R8 next start", first[4], 5);

    sel_on[0 +: SW] = 2'd1;
    par_in[0] = 1'b1;
    run_watch(25, 2, 2, '0);
    chk(hits[0] == 0, "R10 discarded", hits[0], 0);
    chk(gate == '0, "R10 gates", gate, 0);
    drn_cmp = 6'h3F;
    run_watch(12, 0, 0, '0);
    for (int c = 0; c < NCH; c++) chk(hits[c] == 0, "R10 drain ignored", hits[c], 0);
    drn_cmp = '0;
    idle(2);
    en_n = 0;
    #1;
    chk(gate == (par_in | spi_gate), "R1 after enable", gate, par_in | spi_gate);
    check_restart("R9 enable fall");

    rst_pin = 0;
    idle(3);
    chk(sample == '0, "R10 reset pin", sample, 0);
    rst_pin = 1;
    check_restart("R9 reset rise");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule